// File: doc/BRIEF.md
# Event Timer with Selectable Source and Prescaler

This block is a free-running up-counter for a small controller. Each count is triggered by one of two sources. The first is a per-cycle instruction enable from the core. The second is an external input pin, which the block synchronises and then edge-detects; a control bit picks whether its rising or falling edge counts. A divider with a power-of-two ratio can sit between the chosen source and the counter. A control bit can also hand the divider to another user, so that the counter sees every source event.

Software can preload the counter at any time, which makes it possible to time a known interval from a start value. When the counter passes from its all-ones value back to zero, it raises a sticky overflow flag. The flag is ANDed with an enable to form an interrupt request. One 8-bit control register, readable on its own output, holds all mode settings.

Top module: `event_timer`

## Requirements
- R1: In the cycle after reset is sampled, cfg_q is 0xFF, cnt_q is 0, ovf_flag is 0 and irq is 0.
- R2: When cfg bit 5 is 0, the count source is inc_en: each cycle with inc_en high is one source event, and ext_pin has no effect on cnt_q.
- R3: When cfg bit 5 is 1, the count source is ext_pin, passed through two synchronising flops. With cfg bit 4 at 0 a rising edge is an event; at 1 a falling edge is an event. cnt_q moves on the third rising clock edge after the pin changes. inc_en has no effect in this mode.
- R4: When cfg bit 3 is 0, the divider is in the path. The counter advances once every 2^(k+1) source events, where k is cfg bits 2:0 (0 gives 1:2, 7 gives 1:256).
- R5: When cfg bit 3 is 1, the divider is bypassed and the counter advances on every source event.
- R6: A pulse on cnt_wr_en loads cnt_wr_data into cnt_q on the next cycle. The load wins over an increment in the same cycle, and it clears the divider's event count.
- R7: An increment from 0xFF to 0x00 sets ovf_flag in the same cycle the counter wraps. A load never sets it.
- R8: ovf_flag stays set until a cycle with flag_clr high. If a wrap and flag_clr fall in the same cycle, the flag ends up set.
- R9: irq is high exactly when ovf_flag and irq_en are both high.
- R10: A pulse on cfg_wr_en stores all 8 bits of cfg_wr_data, which appear on cfg_q on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inc_en | input | 1 | Internal instruction-cycle count enable |
| ext_pin | input | 1 | Asynchronous external count input |
| cfg_wr_en | input | 1 | Control register write strobe |
| cfg_wr_data | input | 8 | Control register write value |
| cfg_q | output | 8 | Control register contents |
| cnt_wr_en | input | 1 | Counter preload strobe |
| cnt_wr_data | input | CNT_W | Counter preload value |
| cnt_q | output | CNT_W | Counter value |
| flag_clr | input | 1 | Clears the overflow flag |
| irq_en | input | 1 | Overflow interrupt enable |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: an 8-bit counter and a 3-bit ratio code that reaches an 8-bit divider. At this size, random preloads near 0xFF make counter wraps common. The full 1:256 ratio fits in a run of a few hundred cycles, so the largest divide setting is exercised directly, along with the rollover of the divider into its next period.

// File: rtl/event_timer_pkg.sv
package event_timer_pkg;

    localparam int SEL_W = 3;
    localparam int DIV_W = 1 << SEL_W;
    localparam logic [7:0] CFG_RESET = 8'hFF;

    typedef struct packed {
        logic [1:0]       spare;
        logic             use_pin;
        logic             pin_falling;
        logic             div_bypass;
        logic [SEL_W-1:0] div_sel;
    } tmr_cfg_t;

    function automatic logic [DIV_W-1:0] div_mask(input logic [SEL_W-1:0] sel);
        logic [DIV_W-1:0] m;
        for (int i = 0; i < DIV_W; i++) begin
            m[i] = (i <= int'(sel));
        end
        return m;
    endfunction

endpackage

// File: rtl/event_timer_sync.sv
module event_timer_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    input  logic falling,
    output logic event_o
);
    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-1:0], pin};
    end

    logic cur, prev;
    assign cur  = chain[STAGES-1];
    assign prev = chain[STAGES];
    assign event_o = falling ? (prev & ~cur) : (cur & ~prev);
endmodule

// File: rtl/event_timer_div.sv
module event_timer_div
    import event_timer_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             src_ev,
    input  logic             bypass,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    logic [DIV_W-1:0] div_cnt;
    logic [DIV_W-1:0] mask;

    assign mask = div_mask(sel);
    assign tick = bypass ? src_ev : (src_ev && ((div_cnt & mask) == mask));

    always_ff @(posedge clk) begin
        if (rst || clr)               div_cnt <= '0;
        else if (src_ev && !bypass)   div_cnt <= div_cnt + 1'b1;
    end
endmodule

// File: rtl/event_timer_core.sv
module event_timer_core #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] cnt,
    output logic             flag
);
    logic wrap;
    assign wrap = tick && !wr_en && (cnt == '1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            flag <= 1'b0;
        end else begin
            if (wr_en)     cnt <= wr_data;
            else if (tick) cnt <= cnt + 1'b1;
            flag <= wrap | (flag & ~flag_clr);
        end
    end
endmodule

// File: rtl/event_timer.sv
module event_timer
    import event_timer_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc_en,
    input  logic             ext_pin,
    input  logic             cfg_wr_en,
    input  logic [7:0]       cfg_wr_data,
    output logic [7:0]       cfg_q,
    input  logic             cnt_wr_en,
    input  logic [CNT_W-1:0] cnt_wr_data,
    output logic [CNT_W-1:0] cnt_q,
    input  logic             flag_clr,
    input  logic             irq_en,
    output logic             ovf_flag,
    output logic             irq
);
    tmr_cfg_t cfg;
    logic     pin_ev, src_ev, tick;

    always_ff @(posedge clk) begin
        if (rst)            cfg <= tmr_cfg_t'(CFG_RESET);
        else if (cfg_wr_en) cfg <= tmr_cfg_t'(cfg_wr_data);
    end
    assign cfg_q = cfg;

    event_timer_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst(rst), .pin(ext_pin),
        .falling(cfg.pin_falling), .event_o(pin_ev)
    );

    assign src_ev = cfg.use_pin ? pin_ev : inc_en;

    event_timer_div u_div (
        .clk(clk), .rst(rst), .clr(cnt_wr_en), .src_ev(src_ev),
        .bypass(cfg.div_bypass), .sel(cfg.div_sel), .tick(tick)
    );

    event_timer_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst(rst), .tick(tick), .wr_en(cnt_wr_en),
        .wr_data(cnt_wr_data), .flag_clr(flag_clr),
        .cnt(cnt_q), .flag(ovf_flag)
    );

    assign irq = ovf_flag & irq_en;
endmodule

// File: rtl/event_timer_chk.sv
module event_timer_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             cfg_wr_en,
    input logic [7:0]       cfg_wr_data,
    input logic [7:0]       cfg_q,
    input logic             cnt_wr_en,
    input logic [CNT_W-1:0] cnt_wr_data,
    input logic [CNT_W-1:0] cnt_q,
    input logic             flag_clr,
    input logic             irq_en,
    input logic             ovf_flag,
    input logic             irq
);
    assert_reset_R1: assert property (@(posedge clk)
        rst |=> (cnt_q == '0 && cfg_q == 8'hFF && !ovf_flag));

    assert_step_R2: assert property (@(posedge clk) disable iff (rst)
        !cnt_wr_en |=> (cnt_q == $past(cnt_q) || cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

    assert_load_R6: assert property (@(posedge clk) disable iff (rst)
        cnt_wr_en |=> cnt_q == $past(cnt_wr_data));

    assert_wrap_R7: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == '1 && !cnt_wr_en) |=> (cnt_q != '0 || ovf_flag));

    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (ovf_flag && !flag_clr) |=> ovf_flag);

    assert_irq_flag_R9: assert property (@(posedge clk) disable iff (rst)
        irq |-> (ovf_flag && irq_en));

    assert_cfg_R10: assert property (@(posedge clk) disable iff (rst)
        cfg_wr_en |=> cfg_q == $past(cfg_wr_data));
endmodule

bind event_timer event_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .cfg_q(cfg_q), .cnt_wr_en(cnt_wr_en), .cnt_wr_data(cnt_wr_data),
    .cnt_q(cnt_q), .flag_clr(flag_clr), .irq_en(irq_en),
    .ovf_flag(ovf_flag), .irq(irq)
);

// File: tb/event_timer_bench.sv
`timescale 1ns/1ps
module event_timer_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       inc_en = 1'b0, ext_pin = 1'b0;
    logic       cfg_wr_en = 1'b0, cnt_wr_en = 1'b0;
    logic [7:0] cfg_wr_data = '0, cnt_wr_data = '0;
    logic       flag_clr = 1'b0, irq_en = 1'b0;
    logic [7:0] cfg_q, cnt_q;
    logic       ovf_flag, irq;

    always #10 clk = ~clk;

    event_timer u_event_timer (
        .clk(clk), .rst(rst), .inc_en(inc_en), .ext_pin(ext_pin),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data), .cfg_q(cfg_q),
        .cnt_wr_en(cnt_wr_en), .cnt_wr_data(cnt_wr_data), .cnt_q(cnt_q),
        .flag_clr(flag_clr), .irq_en(irq_en), .ovf_flag(ovf_flag), .irq(irq)
    );

    int    n_vec = 0, n_bad = 0;
    string tag = "R1";
    bit    done = 1'b0;

    // reference state, derived from the requirements
    logic [2:0] m_pin;
    int         m_div, m_cnt;
    logic       m_flag;
    logic [7:0] m_cfg;

    function automatic bit model_event(logic [7:0] c, logic [2:0] s, logic ie);
        if (!c[5]) return ie;
        if (c[4])  return !s[1] && s[2];
        return s[1] && !s[2];
    endfunction

    task automatic model_step();
        bit ev, tk, setf;
        int ratio;
        if (rst) begin
            m_pin = '0; m_div = 0; m_cnt = 0; m_flag = 1'b0; m_cfg = 8'hFF;
            return;
        end
        ev = model_event(m_cfg, m_pin, inc_en);
        ratio = 1 << (int'(m_cfg[2:0]) + 1);
        tk = m_cfg[3] ? ev : (ev && (((m_div + 1) % ratio) == 0));
        setf = 1'b0;
        if (cnt_wr_en) begin
            m_cnt = cnt_wr_data; m_div = 0;
        end else begin
            if (ev && !m_cfg[3]) m_div = (m_div + 1) % 256;
            if (tk) begin
                if (m_cnt == 255) setf = 1'b1;
                m_cnt = (m_cnt + 1) % 256;
            end
        end
        m_flag = setf | (m_flag & ~flag_clr);
        if (cfg_wr_en) m_cfg = cfg_wr_data;
        m_pin = {m_pin[1:0], ext_pin};
    endtask

    task automatic chk(string t, string nm, logic [7:0] act, logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", t, nm, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
        chk(tag, "cnt", cnt_q, 8'(m_cnt));
        chk(tag, "flag", {7'd0, ovf_flag}, {7'd0, m_flag});
        chk(tag, "irq R9", {7'd0, irq}, {7'd0, m_flag & irq_en});
        chk(tag, "cfg R10", cfg_q, m_cfg);
        cfg_wr_en = 1'b0; cnt_wr_en = 1'b0; flag_clr = 1'b0;
    endtask

    task automatic wr_cfg(logic [7:0] v);
        cfg_wr_en = 1'b1; cfg_wr_data = v; cyc();
    endtask

    task automatic wr_cnt(logic [7:0] v);
        cnt_wr_en = 1'b1; cnt_wr_data = v; cyc();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        tag = "R1";
        cyc(); cyc();
        rst = 1'b0;
        chk("R1", "reset cfg", cfg_q, 8'hFF);
        chk("R1", "reset cnt", cnt_q, 8'h00);
        chk("R1", "reset flag", {7'd0, ovf_flag}, 8'h00);

        tag = "R10"; wr_cfg(8'h08);                 // internal source, bypass
        tag = "R2 R5";
        for (int i = 0; i < 40; i++) begin
            inc_en = 1'($urandom_range(0, 1)); ext_pin = ~ext_pin; cyc();
        end

        tag = "R6"; inc_en = 1'b1; wr_cnt(8'hF0);
        chk("R6", "load wins", cnt_q, 8'hF0);
        tag = "R7";
        repeat (16) cyc();
        chk("R7", "wrapped", cnt_q, 8'h00);
        chk("R7", "flag set", {7'd0, ovf_flag}, 8'h01);
        tag = "R9"; irq_en = 1'b1; cyc();
        chk("R9", "irq on", {7'd0, irq}, 8'h01);
        irq_en = 1'b0; cyc();
        chk("R9", "irq masked", {7'd0, irq}, 8'h00);
        tag = "R8"; inc_en = 1'b0; repeat (5) cyc();
        chk("R8", "flag held", {7'd0, ovf_flag}, 8'h01);
        flag_clr = 1'b1; cyc();
        chk("R8", "flag cleared", {7'd0, ovf_flag}, 8'h00);
        wr_cnt(8'hFF);
        inc_en = 1'b1; flag_clr = 1'b1; cyc();
        chk("R8", "set beats clear", {7'd0, ovf_flag}, 8'h01);
        flag_clr = 1'b1; inc_en = 1'b0; cyc();

        tag = "R4"; wr_cfg(8'h00);                  // divide by 2
        inc_en = 1'b1; repeat (20) cyc();
        wr_cfg(8'h07);                              // divide by 256
        wr_cnt(8'h00);
        repeat (512) cyc();
        chk("R4", "div256 count", cnt_q, 8'h02);
        wr_cfg(8'h03); repeat (40) cyc();
        inc_en = 1'b0;

        tag = "R3"; wr_cfg(8'h28);                  // pin, rising, bypass
        wr_cnt(8'h10);
        ext_pin = 1'b1; cyc(); cyc();
        chk("R3", "not yet", cnt_q, 8'h10);
        cyc();
        chk("R3", "rise counted", cnt_q, 8'h11);
        wr_cfg(8'h38);                              // falling
        ext_pin = 1'b0; repeat (3) cyc();
        chk("R3", "fall counted", cnt_q, 8'h12);
        inc_en = 1'b1; repeat (10) cyc();
        chk("R3", "inc_en ignored", cnt_q, 8'h12);

        tag = "random R2 R3 R4 R5 R6 R7 R8";
        for (int i = 0; i < 4000; i++) begin
            inc_en = 1'($urandom_range(0, 1));
            if ($urandom_range(0, 2) == 0) ext_pin = ~ext_pin;
            if ($urandom_range(0, 63) == 0) begin
                cfg_wr_en = 1'b1; cfg_wr_data = 8'($urandom);
            end
            if ($urandom_range(0, 31) == 0) begin
                cnt_wr_en = 1'b1;
                cnt_wr_data = ($urandom_range(0, 1) == 1) ? 8'hFE : 8'($urandom);
            end
            flag_clr = ($urandom_range(0, 15) == 0);
            if ($urandom_range(0, 7) == 0) irq_en = ~irq_en;
            cyc();
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule